// File: doc/BRIEF.md
# SQE Heartbeat and Carrier Sense Generator

This block sits on the MAC side of a 10BASE-T media independent interface. It derives carrier sense from transmit and receive activity. After each transmitted frame it also produces the signal-quality-error test pulse, often called the heartbeat, on the collision line. The heartbeat is merged by OR with the collision signal from the real detector. Its timer runs on the transmit clock.

Three controls decide whether a heartbeat is issued: the link speed flag, a repeater-mode bit and an inhibit bit. The heartbeat is only sent in 10BASE-T operation, and only when neither repeater mode nor the inhibit bit is set. Repeater mode also makes carrier sense follow receive activity alone, and it forces the full-duplex indication off. The decision to arm a heartbeat is taken at the clock edge that sees the end of transmission. If transmission starts again before the pulse begins, the pending heartbeat is dropped.

Top module: `hb_crs_top`

## Requirements
- R1: With repeater mode clear, crs_o is high exactly when tx_en_i or rx_act_i is high. This path is combinational.
- R2: With repeater mode set, crs_o equals rx_act_i, and transmit activity has no effect on it.
- R3: The end of a frame is the first rising clock edge that samples tx_en_i low after sampling it high; call it edge 1. When the heartbeat is enabled, col_o rises after edge DELAY+1 (DELAY=8 by default).
- R4: The heartbeat stays high for exactly WIDTH clock cycles (10 by default) and then returns low.
- R5: If tx_en_i is sampled high again before the heartbeat starts, the pending heartbeat is cancelled and col_o stays low.
- R6: An inhibit input of 1, sampled at the end-of-frame edge, suppresses the heartbeat. An inhibit of 0 allows it.
- R7: Repeater mode suppresses the heartbeat even when the inhibit input is 0.
- R8: When the 10BASE-T mode flag is 0, no heartbeat is produced.
- R9: col_o is the OR of the heartbeat and col_ext_i.
- R10: duplex_o equals fdx_req_i while repeater mode is clear, and is 0 while repeater mode is set.
- R11: During and right after reset, col_o is low and no heartbeat is pending. A low tx_en_i after reset is not treated as an end of frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_act_i | input | 1 | Receive activity from the line side |
| mode_10bt_i | input | 1 | 1 when the link runs at 10BASE-T |
| rptr_mode_i | input | 1 | Repeater operation select |
| sqe_inh_i | input | 1 | 1 suppresses the heartbeat |
| fdx_req_i | input | 1 | Requested full-duplex setting |
| col_ext_i | input | 1 | Collision from the real detector |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision, merged with the heartbeat |
| duplex_o | output | 1 | Effective full-duplex indication |

## Verification
The case that is hardest to reach is a new frame that starts in the short gap between the end-of-frame edge and the start of the pulse. The stimulus drops tx_en_i at a falling clock edge and raises it again two edges later, well inside the DELAY window. It then watches col_o through the whole span where the pulse would have appeared. After that it lowers tx_en_i once more, to confirm that the timer re-arms cleanly from the cancelled state.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_e;

  // bits needed to count up to the larger of the two windows
  function automatic int cnt_bits(input int dly, input int wid);
    int top;
    top = (dly > wid) ? dly : wid;
    return $clog2(top + 1);
  endfunction

  // carrier sense selection
  function automatic logic carrier(input logic rptr, input logic tx, input logic rx);
    return rptr ? rx : (tx | rx);
  endfunction
endpackage

// File: rtl/hb_edge_det.sv
module hb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  output logic fall_evt_o
);
  logic tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_en_i;
  end

  assign fall_evt_o = tx_q & ~tx_en_i;

  // R11: no end-of-frame event straight out of reset
  assert_no_fall_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fall_evt_o);
endmodule

// File: rtl/hb_timer.sv
module hb_timer #(
  parameter int DELAY = 8,
  parameter int WIDTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt_i,
  input  logic tx_en_i,
  input  logic arm_ok_i,
  output logic hb_o
);
  import hb_pkg::*;

  localparam int CW = cnt_bits(DELAY, WIDTH);
  localparam logic [CW-1:0] DLY_LAST = CW'(DELAY - 1);
  localparam logic [CW-1:0] WID_LAST = CW'(WIDTH - 1);

  hb_state_e state;
  logic [CW-1:0] cnt;
  logic start_evt;
  logic cancel_evt;

  assign start_evt  = fall_evt_i & arm_ok_i & (state != HB_PULSE);
  assign cancel_evt = (state == HB_WAIT) & tx_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HB_IDLE;
      cnt   <= '0;
    end else if (start_evt) begin
      state <= HB_WAIT;
      cnt   <= '0;
    end else begin
      unique case (state)
        HB_WAIT: begin
          if (cancel_evt) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else if (cnt == DLY_LAST) begin
            state <= HB_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HB_PULSE: begin
          if (cnt == WID_LAST) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= HB_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign hb_o = (state == HB_PULSE);

  // checker state: length of the current pulse
  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (hb_o) hi_cnt <= hi_cnt + 1'b1;
    else           hi_cnt <= '0;
  end

  // R4: each pulse lasts WIDTH cycles
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_o) |-> hi_cnt == CW'(WIDTH));

  // R3: a pulse only begins after a quiet transmit line
  assert_start_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hb_o) |-> !$past(tx_en_i));

  // R5: a new frame during the wait kills the pending pulse
  assert_cancel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt && !start_evt |=> !hb_o);
endmodule

// File: rtl/hb_crs_top.sv
module hb_crs_top #(
  parameter int DELAY = 8,
  parameter int WIDTH = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en_i,
  input  logic rx_act_i,
  input  logic mode_10bt_i,
  input  logic rptr_mode_i,
  input  logic sqe_inh_i,
  input  logic fdx_req_i,
  input  logic col_ext_i,
  output logic crs_o,
  output logic col_o,
  output logic duplex_o
);
  import hb_pkg::*;

  logic fall_evt;
  logic arm_ok;
  logic hb;

  assign arm_ok = mode_10bt_i & ~rptr_mode_i & ~sqe_inh_i;

  hb_edge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en_i   (tx_en_i),
    .fall_evt_o(fall_evt)
  );

  hb_timer #(.DELAY(DELAY), .WIDTH(WIDTH)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_evt_i(fall_evt),
    .tx_en_i   (tx_en_i),
    .arm_ok_i  (arm_ok),
    .hb_o      (hb)
  );

  assign crs_o    = carrier(rptr_mode_i, tx_en_i, rx_act_i);
  assign col_o    = hb | col_ext_i;
  assign duplex_o = fdx_req_i & ~rptr_mode_i;

  // R2: in repeater mode carrier never shows without receive activity
  assert_rptr_crs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_mode_i && !rx_act_i |-> !crs_o);

  // R10: repeater mode forbids full duplex
  assert_rptr_duplex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_mode_i |-> !duplex_o);

  // R9: a real collision always reaches the output
  assert_ext_col_R9: assert property (@(posedge clk) disable iff (!rst_n)
    col_ext_i |-> col_o);

  // R1: outside repeater mode transmit activity raises carrier
  assert_tx_crs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rptr_mode_i && tx_en_i |-> crs_o);
endmodule

// File: tb/hb_crs_top_tb_top.sv
module hb_crs_top_tb_top;
  localparam int DELAY = 8;
  localparam int WIDTH = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_act = 1'b0, m10 = 1'b1, rptr = 1'b0;
  logic inh = 1'b0, fdx = 1'b0, col_ext = 1'b0;
  logic crs, col, duplex;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  hb_crs_top #(.DELAY(DELAY), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .rx_act_i(rx_act),
    .mode_10bt_i(m10), .rptr_mode_i(rptr), .sqe_inh_i(inh),
    .fdx_req_i(fdx), .col_ext_i(col_ext),
    .crs_o(crs), .col_o(col), .duplex_o(duplex)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one frame ending; checks col_o cycle by cycle against the heartbeat window
  task automatic frame_end(input string req, input logic expect_hb);
    @(negedge clk); tx_en = 1'b1;
    repeat (4) @(negedge clk);
    tx_en = 1'b0;
    for (int n = 1; n <= DELAY + WIDTH + 3; n++) begin
      @(posedge clk); @(negedge clk);
      check(req, col, expect_hb && n >= DELAY + 1 && n <= DELAY + WIDTH);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R11 col in reset", col, 1'b0);
    rst_n = 1'b1;
    for (int n = 0; n < DELAY + WIDTH + 2; n++) begin
      @(negedge clk);
      check("R11 no heartbeat after reset", col, 1'b0);
    end
  endtask

  task automatic t_crs;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      rptr = p[2]; tx_en = p[1]; rx_act = p[0];
      #1;
      if (rptr) check("R2 repeater crs", crs, rx_act);
      else      check("R1 normal crs", crs, tx_en | rx_act);
    end
    @(negedge clk); rptr = 1'b0; tx_en = 1'b0; rx_act = 1'b0;
    repeat (DELAY + WIDTH + 4) @(negedge clk);
  endtask

  task automatic t_cancel;
    @(negedge clk); tx_en = 1'b1;
    repeat (4) @(negedge clk);
    tx_en = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    tx_en = 1'b1;
    for (int n = 0; n < DELAY + WIDTH + 3; n++) begin
      @(posedge clk); @(negedge clk);
      check("R5 cancelled heartbeat", col, 1'b0);
    end
    tx_en = 1'b0;
    for (int n = 1; n <= DELAY + WIDTH + 3; n++) begin
      @(posedge clk); @(negedge clk);
      check("R5 re-arm after cancel", col, n >= DELAY + 1 && n <= DELAY + WIDTH);
    end
  endtask

  task automatic t_duplex_col;
    @(negedge clk); fdx = 1'b1; rptr = 1'b0; #1;
    check("R10 duplex passes", duplex, 1'b1);
    rptr = 1'b1; #1;
    check("R10 duplex forced off", duplex, 1'b0);
    rptr = 1'b0; fdx = 1'b0; col_ext = 1'b1; #1;
    check("R9 external collision", col, 1'b1);
    col_ext = 1'b0; #1;
    check("R9 idle collision", col, 1'b0);
  endtask

  initial begin
    t_reset();
    t_crs();
    frame_end("R3 R4 heartbeat window", 1'b1);
    inh = 1'b1;
    frame_end("R6 inhibit", 1'b0);
    inh = 1'b0;
    rptr = 1'b1;
    frame_end("R7 repeater suppresses", 1'b0);
    rptr = 1'b0;
    m10 = 1'b0;
    frame_end("R8 not 10BASE-T", 1'b0);
    m10 = 1'b1;
    frame_end("R6 enabled again", 1'b1);
    t_cancel();
    t_duplex_col();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule